// File: doc/BRIEF.md
# Voltage and Synchronism Energizing Check

This block decides whether a breaker whose three poles are all open may be reclosed. It uses the voltage state on each side of the breaker and the state of an external synchronism element. It takes five detector flags: bus over-voltage, bus under-voltage, line over-voltage, line under-voltage and synchronism-operate. It also takes a two-bit energizing direction select and a periodic tick that marks 10 ms of time. The analog measurement and the phase-angle comparison happen upstream and are not part of this block.

There are three permission paths, and each has its own on-delay timer. The synchronism path handles the case where both sides are live. The live-bus/dead-line path energizes the line from the bus. The dead-bus/live-line path energizes the bus from the line. Each timer is a small state machine with three states. TS_IDLE moves to TS_RUN when the condition appears. TS_RUN moves to TS_UP on the tick that completes the delay. TS_RUN or TS_UP moves back to TS_IDLE as soon as the condition drops. The direction select controls which picked-up paths are combined into the permit output. A fourth timer of the same kind, on line over-voltage alone, drives a three-phase live-line flag. When both sides are dead, no path ever grants permission.

The delays are parameters counted in ticks. The live-bus/dead-line delay allows a range ten times longer than the others.

Top module: `egc_energize_check`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, all five outputs are low.
- R2: sync_ready goes high after sync_ok has been held high across SYNC_DLY ticks (counting the tick in the cycle where the condition first appears), and stays high while sync_ok stays high.
- R3: lbdl_ready goes high after bus_ov and line_uv have both been held high across LBDL_DLY ticks.
- R4: dbll_ready goes high after bus_uv and line_ov have both been held high across DBLL_DLY ticks.
- R5: When a timer's condition drops, its output goes low in the next cycle and its tick count restarts from zero.
- R6: Timers advance only on cycles where tick is high; cycles without a tick do not change a count.
- R7: energize_mode 2'b00 (off) forces permit low whatever the path states.
- R8: energize_mode 2'b01 (sync only) makes permit equal to sync_ready. The voltage paths have no effect on permit.
- R9: energize_mode 2'b10 (dead-bus direction) makes permit equal to sync_ready OR dbll_ready.
- R10: energize_mode 2'b11 (live-bus direction) makes permit equal to sync_ready OR lbdl_ready.
- R11: live_line goes high after line_ov has been held across LL_DLY ticks, in every mode.
- R12: With bus_uv and line_uv high and sync_ok low, permit stays low in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per 10 ms time step |
| bus_ov | input | 1 | Busbar over-voltage detector (bus live) |
| bus_uv | input | 1 | Busbar under-voltage detector (bus dead) |
| line_ov | input | 1 | Line over-voltage detector (line live) |
| line_uv | input | 1 | Line under-voltage detector (line dead) |
| sync_ok | input | 1 | Synchronism element operate |
| energize_mode | input | 2 | 00 off, 01 sync only, 10 dead-bus direction, 11 live-bus direction |
| permit | output | 1 | Reclose permission |
| sync_ready | output | 1 | Delayed synchronism path |
| lbdl_ready | output | 1 | Delayed live-bus/dead-line path |
| dbll_ready | output | 1 | Delayed dead-bus/live-line path |
| live_line | output | 1 | Delayed three-phase live-line flag |

## Verification
The dead-bus/live-line timer and the live-line timer both depend on line over-voltage. With equal delays they can pick up on the same tick. The bench sets DBLL_DLY equal to LL_DLY and raises bus_uv and line_ov together in the dead-bus direction. It then expects dbll_ready, live_line and permit to rise in the same cycle, and to fall together in the cycle after line_ov drops. A model in the scoreboard counts ticks for each path on its own and judges all five outputs in every cycle.

// File: rtl/egc_pkg.sv
package egc_pkg;

    typedef enum logic [1:0] {
        EM_OFF     = 2'b00,
        EM_SYNC    = 2'b01,
        EM_DEADBUS = 2'b10,
        EM_LIVEBUS = 2'b11
    } egc_mode_e;

    typedef enum logic [1:0] {
        TS_IDLE = 2'b00,
        TS_RUN  = 2'b01,
        TS_UP   = 2'b10
    } tmr_state_e;

    localparam int NUM_TIMERS = 4;
    localparam int IDX_SYNC   = 0;
    localparam int IDX_LBDL   = 1;
    localparam int IDX_DBLL   = 2;
    localparam int IDX_LL     = 3;

endpackage

// File: rtl/egc_ondelay.sv
module egc_ondelay
    import egc_pkg::*;
#(
    parameter int DLY = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic picked
);

    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    tmr_state_e        state, state_nxt;
    logic [CW-1:0]     cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            TS_IDLE, TS_RUN: begin
                if (!cond) begin
                    state_nxt = TS_IDLE;
                    cnt_nxt   = '0;
                end else if (tick) begin
                    if (cnt == LAST) begin
                        state_nxt = TS_UP;
                        cnt_nxt   = '0;
                    end else begin
                        state_nxt = TS_RUN;
                        cnt_nxt   = cnt + 1'b1;
                    end
                end else begin
                    state_nxt = TS_RUN;
                end
            end
            TS_UP: begin
                if (!cond) begin
                    state_nxt = TS_IDLE;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = TS_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // output logic
    always_comb begin
        picked = (state == TS_UP);
    end

    // R5: losing the condition clears the output in the next cycle
    a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !picked);

    // R6: a pick-up only follows a tick
    a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(picked) |-> $past(tick));

    // R5: a pick-up only follows a held condition
    a_r5_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(picked) |-> $past(cond));

endmodule

// File: rtl/egc_gate.sv
module egc_gate
    import egc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_raw,
    input  logic       sync_q,
    input  logic       lbdl_q,
    input  logic       dbll_q,
    output logic       permit
);

    egc_mode_e mode;

    always_comb begin
        mode = egc_mode_e'(mode_raw);
    end

    always_comb begin
        permit = 1'b0;
        unique case (mode)
            EM_OFF:     permit = 1'b0;
            EM_SYNC:    permit = sync_q;
            EM_DEADBUS: permit = sync_q | dbll_q;
            EM_LIVEBUS: permit = sync_q | lbdl_q;
            default:    permit = 1'b0;
        endcase
    end

    // R7: off setting never grants
    a_r7_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_raw == 2'b00) |-> !permit);

    // R8: in sync-only setting the voltage paths alone never grant
    a_r8_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_raw == 2'b01 && !sync_q) |-> !permit);

endmodule

// File: rtl/egc_energize_check.sv
module egc_energize_check
    import egc_pkg::*;
#(
    parameter int SYNC_DLY = 50,
    parameter int LBDL_DLY = 500,
    parameter int DBLL_DLY = 50,
    parameter int LL_DLY   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_ov,
    input  logic       bus_uv,
    input  logic       line_ov,
    input  logic       line_uv,
    input  logic       sync_ok,
    input  logic [1:0] energize_mode,
    output logic       permit,
    output logic       sync_ready,
    output logic       lbdl_ready,
    output logic       dbll_ready,
    output logic       live_line
);

    localparam int DLYS [NUM_TIMERS] = '{SYNC_DLY, LBDL_DLY, DBLL_DLY, LL_DLY};

    logic [NUM_TIMERS-1:0] path_cond;
    logic [NUM_TIMERS-1:0] path_up;

    always_comb begin
        path_cond[IDX_SYNC] = sync_ok;
        path_cond[IDX_LBDL] = bus_ov & line_uv;
        path_cond[IDX_DBLL] = bus_uv & line_ov;
        path_cond[IDX_LL]   = line_ov;
    end

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        egc_ondelay #(.DLY(DLYS[g])) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .cond   (path_cond[g]),
            .picked (path_up[g])
        );
    end

    egc_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_raw (energize_mode),
        .sync_q   (path_up[IDX_SYNC]),
        .lbdl_q   (path_up[IDX_LBDL]),
        .dbll_q   (path_up[IDX_DBLL]),
        .permit   (permit)
    );

    always_comb begin
        sync_ready = path_up[IDX_SYNC];
        lbdl_ready = path_up[IDX_LBDL];
        dbll_ready = path_up[IDX_DBLL];
        live_line  = path_up[IDX_LL];
    end

    // R12: permission needs a live side or synchronism in the previous cycle
    a_r12_needs_live_side: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> $past(sync_ok || (bus_ov && line_uv) || (bus_uv && line_ov)));

    // R11: live-line flag needs line over-voltage in the previous cycle
    a_r11_ll_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        live_line |-> $past(line_ov));

endmodule

// File: tb/egc_energize_check_bench.sv
module egc_energize_check_bench;

    localparam int SYNC_D = 3;
    localparam int LBDL_D = 5;
    localparam int DBLL_D = 4;
    localparam int LL_D   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic bus_ov = 1'b0, bus_uv = 1'b0, line_ov = 1'b0, line_uv = 1'b0, sync_ok = 1'b0;
    logic [1:0] energize_mode = 2'b00;
    logic permit, sync_ready, lbdl_ready, dbll_ready, live_line;

    always #4 clk = ~clk;

    egc_energize_check #(
        .SYNC_DLY(SYNC_D), .LBDL_DLY(LBDL_D), .DBLL_DLY(DBLL_D), .LL_DLY(LL_D)
    ) u_egc_energize_check (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_ov(bus_ov), .bus_uv(bus_uv), .line_ov(line_ov), .line_uv(line_uv),
        .sync_ok(sync_ok), .energize_mode(energize_mode),
        .permit(permit), .sync_ready(sync_ready), .lbdl_ready(lbdl_ready),
        .dbll_ready(dbll_ready), .live_line(live_line)
    );

    typedef struct {
        logic [4:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    int c_sy = 0, c_lb = 0, c_db = 0, c_ll = 0;
    bit driving = 1'b0;

    function automatic int adv(int c, bit cond, bit tk);
        if (!cond) return 0;
        if (tk) return c + 1;
        return c;
    endfunction

    // driver: one cycle of stimulus plus the expected outputs after the next edge
    task automatic step(input bit bo, bu, lo, lu, sy, input logic [1:0] md,
                        input bit tk, input string tag);
        exp_t e;
        bit up_sy, up_lb, up_db, up_ll, pm;
        @(negedge clk);
        bus_ov = bo; bus_uv = bu; line_ov = lo; line_uv = lu; sync_ok = sy;
        energize_mode = md; tick = tk;
        c_sy = adv(c_sy, sy, tk);
        c_lb = adv(c_lb, bo & lu, tk);
        c_db = adv(c_db, bu & lo, tk);
        c_ll = adv(c_ll, lo, tk);
        up_sy = (c_sy >= SYNC_D);
        up_lb = (c_lb >= LBDL_D);
        up_db = (c_db >= DBLL_D);
        up_ll = (c_ll >= LL_D);
        case (md)
            2'b01:   pm = up_sy;
            2'b10:   pm = up_sy | up_db;
            2'b11:   pm = up_sy | up_lb;
            default: pm = 1'b0;
        endcase
        e.val = {pm, up_sy, up_lb, up_db, up_ll};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run(input int n, input bit bo, bu, lo, lu, sy,
                       input logic [1:0] md, input int every, input string tag);
        for (int i = 0; i < n; i++) begin
            step(bo, bu, lo, lu, sy, md, (every > 0) && (i % every == every - 1), tag);
        end
    endtask

    // monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e = exp_q.pop_front();
                act = {permit, sync_ready, lbdl_ready, dbll_ready, live_line};
                total++;
                if (act !== e.val) begin
                    bad++;
                    $display("FAIL %s actual=%b expected=%b", e.tag, act, e.val);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, with conditions present during reset
        bus_ov = 1'b1; line_ov = 1'b1; sync_ok = 1'b1; tick = 1'b1; energize_mode = 2'b11;
        repeat (4) @(posedge clk);
        #2;
        total++;
        if ({permit, sync_ready, lbdl_ready, dbll_ready, live_line} !== 5'b0) begin
            bad++;
            $display("FAIL R1 actual=%b expected=00000",
                     {permit, sync_ready, lbdl_ready, dbll_ready, live_line});
        end
        @(negedge clk);
        bus_ov = 1'b0; line_ov = 1'b0; sync_ok = 1'b0; tick = 1'b0; energize_mode = 2'b00;
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 2'b00, 1, "R1 after release");

        // R2 and R8: sync path, ticks every other cycle
        run(10, 0, 0, 0, 0, 1, 2'b01, 2, "R2 R8 sync pickup");
        // R6: no ticks, held state
        run(6, 0, 0, 0, 0, 0, 2'b01, 0, "R6 idle no tick");
        run(8, 0, 0, 0, 0, 1, 2'b01, 0, "R6 cond without tick");
        run(4, 0, 0, 0, 0, 1, 2'b01, 1, "R6 ticks resume");
        // R5: drop mid-count and restart
        run(2, 0, 0, 0, 0, 0, 2'b01, 1, "R5 drop");
        run(2, 0, 0, 0, 0, 1, 2'b01, 1, "R5 partial");
        run(1, 0, 0, 0, 0, 0, 2'b01, 1, "R5 drop again");
        run(5, 0, 0, 0, 0, 1, 2'b01, 1, "R5 restart from zero");
        run(2, 0, 0, 0, 0, 0, 2'b01, 1, "R5 clear");

        // R8: live-bus/dead-line timed but ignored in sync-only
        run(8, 1, 0, 0, 1, 0, 2'b01, 1, "R3 R8 lbdl ignored");
        // R10 and R3: live-bus direction grants via lbdl
        run(3, 1, 0, 0, 1, 0, 2'b11, 1, "R10 lbdl grants");
        run(2, 0, 0, 0, 0, 0, 2'b11, 1, "R5 lbdl clear");
        run(9, 1, 0, 0, 1, 0, 2'b11, 3, "R3 R10 slow ticks");
        // R10: dead-bus path does not grant in live-bus direction
        run(2, 0, 0, 0, 0, 0, 2'b11, 1, "R10 clear");
        run(8, 0, 1, 1, 0, 0, 2'b11, 1, "R10 dbll ignored");

        // R4, R9, R11: dbll and live-line pick up on the same tick
        run(2, 0, 0, 0, 0, 0, 2'b10, 1, "R9 clear");
        run(7, 0, 1, 1, 0, 0, 2'b10, 1, "R4 R9 R11 coincident pickup");
        run(2, 0, 0, 0, 0, 0, 2'b10, 1, "R5 R11 coincident drop");
        // R9: lbdl path ignored in dead-bus direction
        run(8, 1, 0, 0, 1, 0, 2'b10, 1, "R9 lbdl ignored");
        // R9: sync also grants in dead-bus direction
        run(5, 0, 0, 0, 0, 1, 2'b10, 1, "R9 sync grants");
        run(2, 0, 0, 0, 0, 0, 2'b10, 1, "R9 clear sync");

        // R7: off blocks everything, R11 live-line still works
        run(8, 0, 1, 1, 0, 1, 2'b00, 1, "R7 R11 off blocks");
        run(2, 1, 0, 1, 0, 1, 2'b00, 1, "R7 sync held off");
        // mode changes with sync up: permit follows the select at once
        step(1, 0, 1, 0, 1, 2'b01, 0, "R8 mode to sync");
        step(1, 0, 1, 0, 1, 2'b00, 0, "R7 mode back off");
        run(2, 0, 0, 0, 0, 0, 2'b00, 1, "R7 clear");

        // R12: both sides dead, every mode
        for (int m = 0; m < 4; m++) begin
            run(8, 0, 1, 0, 1, 0, 2'(m), 1, "R12 both dead");
        end

        repeat (3) @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule